// File: doc/BRIEF.md
# Bus Tenure Error Monitor

This block sits next to a system bus arbiter and watches every granted transfer. It times the address phase and the data phase with two counters, each with its own limit. A phase that is not acknowledged in time becomes a latched error event. A transfer error reported by a target is a third event. Software clears the events one bit at a time.

Each event is routed on its own. It can drive a chip-level reset request, or it can drive an interrupt. An interrupt can be a regular one or a machine-check one, and a per-event enable gates it. The address and attribute lines of the transfer that was on the bus when the first event fired are stored. Later events do not overwrite this record until every event bit has been cleared. The record is kept through a hard reset, so after recovering from a bus deadlock software can still read which transfer caused it.

Configuration, status and the stored record sit behind a simple synchronous register port. Each register is 32 bits wide and word aligned. Read data appears one cycle after the read strobe.

Top module: `errmon_top`

## Requirements
- R1: Address phase timing. `addr_start` high in cycle 0 opens the phase. If `addr_done` is not high in any of cycles 1 to L+1, where L is the address limit, event bit 0 is set. If `addr_done` is high in cycle L+1 itself, no event is raised. The word at byte offset 0x10 holds the address limit in bits [15:0].
- R2: Data phase timing. It follows the same rule as R1, using `data_start`, `data_done`, event bit 1, and the data limit in bits [31:16] of offset 0x10.
- R3: After a hard reset, both limits read as all ones, so offset 0x10 reads 0xFFFFFFFF.
- R4: The event status register is at offset 0x00. Bit 2 is set by `xfer_err`. The register is write-one-to-clear, and a written 0 leaves its bit unchanged. A set and a clear of the same bit in the same cycle leave the bit set. The register reads 0 after a hard reset.
- R5: The route register is at offset 0x04, one bit per event, where 1 selects the reset request. `reset_req` is high exactly while some latched event has its route bit set.
- R6: The kind register is at offset 0x08, where 1 selects machine-check. The enable register is at offset 0x0C, where 1 lets the interrupt through. `irq` is high exactly while a latched event has route 0, enable 1 and kind 0. `mcp` is high under the same condition with kind 1. With enable all zero, neither output is high, even though events still latch.
- R7: The first event that fires while the status register is all zero stores `txn_addr` and `txn_attr` of that cycle. They are readable at offsets 0x14 and 0x18. Later events do not change them while any status bit remains set.
- R8: A hard reset (`rst_n` low) keeps the stored address and attributes. Only `por_n` clears them.
- R9: After a hard reset, route, kind and enable all read 0, and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the stored record |
| rst_n | input | 1 | Hard reset, active low; clears all but the stored record |
| addr_start | input | 1 | Address phase begins |
| addr_done | input | 1 | Address phase acknowledged |
| data_start | input | 1 | Data phase begins |
| data_done | input | 1 | Data phase acknowledged |
| xfer_err | input | 1 | Transfer error reported by the target |
| txn_addr | input | AW | Address of the current transfer |
| txn_attr | input | ATW | Attributes of the current transfer |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reset_req | output | 1 | Reset request level |
| irq | output | 1 | Regular interrupt level |
| mcp | output | 1 | Machine-check interrupt level |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a new event and a software clear of that same status bit. The bench asserts `xfer_err` in the very cycle a write-one-to-clear of bit 2 is presented, then reads the status back and expects the bit to still be set. The second pair is a phase acknowledge and a timer expiry. The bench sweeps the acknowledge delay across each small limit, so the acknowledge also falls exactly on the expiry cycle, where it must win and no event may be latched.

// File: rtl/errmon_pkg.sv
package errmon_pkg;
    localparam int unsigned EV_W = 3;
    localparam int unsigned N_TMR = 2;
    typedef logic [EV_W-1:0] ev_vec_t;

    // word index = byte offset >> 2
    localparam logic [2:0] W_STATUS = 3'd0;
    localparam logic [2:0] W_ROUTE  = 3'd1;
    localparam logic [2:0] W_KIND   = 3'd2;
    localparam logic [2:0] W_ENABLE = 3'd3;
    localparam logic [2:0] W_LIMIT  = 3'd4;
    localparam logic [2:0] W_CADDR  = 3'd5;
    localparam logic [2:0] W_CATTR  = 3'd6;

    localparam int unsigned LIM_HI_LSB = 16;
endpackage

// File: rtl/errmon_timer.sv
module errmon_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          done,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        expire = 1'b0;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else if (t_q.run) begin
            if (done) begin
                t_d.run = 1'b0;
            end else if (t_q.cnt == limit) begin
                expire  = 1'b1;
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/errmon_capture.sv
module errmon_capture #(
    parameter int unsigned AW  = 32,
    parameter int unsigned ATW = 8
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           armed,
    input  logic           fire,
    input  logic [AW-1:0]  addr_in,
    input  logic [ATW-1:0] attr_in,
    output logic [AW-1:0]  cap_addr,
    output logic [ATW-1:0] cap_attr
);
    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [ATW-1:0] attr;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (armed && fire) begin
            c_d.addr = addr_in;
            c_d.attr = attr_in;
        end
    end

    // only power-on reset clears the record
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cap_addr = c_q.addr;
    assign cap_attr = c_q.attr;
endmodule

// File: rtl/errmon_route.sv
module errmon_route
    import errmon_pkg::*;
(
    input  ev_vec_t status,
    input  ev_vec_t route,
    input  ev_vec_t kind,
    input  ev_vec_t enable,
    output logic    reset_req,
    output logic    irq,
    output logic    mcp
);
    ev_vec_t to_int;

    always_comb begin
        to_int    = status & ~route & enable;
        reset_req = |(status & route);
        irq       = |(to_int & ~kind);
        mcp       = |(to_int & kind);
    end
endmodule

// File: rtl/errmon_top.sv
module errmon_top
    import errmon_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned ATW = 8,
    parameter int unsigned TW  = 16
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           rst_n,
    input  logic           addr_start,
    input  logic           addr_done,
    input  logic           data_start,
    input  logic           data_done,
    input  logic           xfer_err,
    input  logic [AW-1:0]  txn_addr,
    input  logic [ATW-1:0] txn_attr,
    input  logic           reg_en,
    input  logic           reg_we,
    input  logic [4:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           reset_req,
    output logic           irq,
    output logic           mcp
);
    localparam int unsigned RW = 32;

    typedef struct packed {
        ev_vec_t       status;
        ev_vec_t       route;
        ev_vec_t       kind;
        ev_vec_t       en;
        logic [TW-1:0] alim;
        logic [TW-1:0] dlim;
        logic [RW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_TMR-1:0] t_start, t_done, t_exp;
    logic [TW-1:0]    t_lim [N_TMR];
    ev_vec_t          ev_set, clr, status_q, route_q, kind_q, en_q;
    logic [AW-1:0]    cap_addr_w;
    logic [ATW-1:0]   cap_attr_w;
    logic [2:0]       word;
    logic             wr, rd;

    assign t_start  = {data_start, addr_start};
    assign t_done   = {data_done, addr_done};
    assign t_lim[0] = r_q.alim;
    assign t_lim[1] = r_q.dlim;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        errmon_timer #(.TW(TW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (t_start[g]),
            .done   (t_done[g]),
            .limit  (t_lim[g]),
            .expire (t_exp[g])
        );
    end

    assign ev_set   = rst_n ? {xfer_err, t_exp} : '0;
    assign status_q = r_q.status;
    assign route_q  = r_q.route;
    assign kind_q   = r_q.kind;
    assign en_q     = r_q.en;

    errmon_capture #(.AW(AW), .ATW(ATW)) u_cap (
        .clk      (clk),
        .por_n    (por_n),
        .armed    (status_q == '0),
        .fire     (|ev_set),
        .addr_in  (txn_addr),
        .attr_in  (txn_attr),
        .cap_addr (cap_addr_w),
        .cap_attr (cap_attr_w)
    );

    errmon_route u_route (
        .status    (status_q),
        .route     (route_q),
        .kind      (kind_q),
        .enable    (en_q),
        .reset_req (reset_req),
        .irq       (irq),
        .mcp       (mcp)
    );

    always_comb begin
        r_d  = r_q;
        wr   = reg_en && reg_we;
        rd   = reg_en && !reg_we;
        word = reg_addr[4:2];
        clr  = '0;
        if (wr) begin
            case (word)
                W_STATUS: clr    = reg_wdata[EV_W-1:0];
                W_ROUTE:  r_d.route = reg_wdata[EV_W-1:0];
                W_KIND:   r_d.kind  = reg_wdata[EV_W-1:0];
                W_ENABLE: r_d.en    = reg_wdata[EV_W-1:0];
                W_LIMIT: begin
                    r_d.alim = reg_wdata[TW-1:0];
                    r_d.dlim = reg_wdata[LIM_HI_LSB +: TW];
                end
                default: ;
            endcase
        end
        // a new event wins over a clear of the same bit
        r_d.status = (r_q.status & ~clr) | ev_set;
        if (rd) begin
            case (word)
                W_STATUS: r_d.rdata = RW'(r_q.status);
                W_ROUTE:  r_d.rdata = RW'(r_q.route);
                W_KIND:   r_d.rdata = RW'(r_q.kind);
                W_ENABLE: r_d.rdata = RW'(r_q.en);
                W_LIMIT:  r_d.rdata = RW'(r_q.alim) | (RW'(r_q.dlim) << LIM_HI_LSB);
                W_CADDR:  r_d.rdata = RW'(cap_addr_w);
                W_CATTR:  r_d.rdata = RW'(cap_attr_w);
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.alim <= '1;
            r_q.dlim <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;
endmodule

// File: rtl/errmon_checker.sv
module errmon_checker
    import errmon_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned ATW = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input ev_vec_t          ev_set,
    input ev_vec_t          status,
    input ev_vec_t          route,
    input ev_vec_t          en,
    input logic             addr_done,
    input logic             data_done,
    input logic [N_TMR-1:0] t_exp,
    input logic [AW-1:0]    cap_addr,
    input logic [ATW-1:0]   cap_attr,
    input logic             reset_req,
    input logic             irq,
    input logic             mcp
);
    a_r1_ack_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_exp[0] && addr_done));

    a_r2_ack_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_exp[1] && data_done));

    a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((status & $past(ev_set)) == $past(ev_set)));

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(ev_set)) == '0);

    a_r5_route_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_set & route) != '0) && $stable(route) |=> reset_req);

    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (!irq && !mcp));

    a_r7_capture_held: assert property (@(posedge clk) disable iff (!por_n)
        (status != '0) |=> ($stable(cap_addr) && $stable(cap_attr)));
endmodule

bind errmon_top errmon_checker #(.AW(AW), .ATW(ATW)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .ev_set    (ev_set),
    .status    (status_q),
    .route     (route_q),
    .en        (en_q),
    .addr_done (addr_done),
    .data_done (data_done),
    .t_exp     (t_exp),
    .cap_addr  (cap_addr_w),
    .cap_attr  (cap_attr_w),
    .reset_req (reset_req),
    .irq       (irq),
    .mcp       (mcp)
);

// File: tb/test_errmon_top.sv
module test_errmon_top;
    localparam int AW = 32;
    localparam int ATW = 8;
    localparam logic [4:0] O_ST = 5'h00, O_RT = 5'h04, O_KD = 5'h08,
                           O_EN = 5'h0C, O_LIM = 5'h10, O_CA = 5'h14, O_CT = 5'h18;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic addr_start = 0, addr_done = 0, data_start = 0, data_done = 0, xfer_err = 0;
    logic [AW-1:0] txn_addr = '0;
    logic [ATW-1:0] txn_attr = '0;
    logic reg_en = 0, reg_we = 0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic reset_req, irq, mcp;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    errmon_top #(.AW(AW), .ATW(ATW), .TW(16)) i_errmon_top (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .addr_start(addr_start), .addr_done(addr_done),
        .data_start(data_start), .data_done(data_done), .xfer_err(xfer_err),
        .txn_addr(txn_addr), .txn_attr(txn_attr),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reset_req(reset_req), .irq(irq), .mcp(mcp)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [4:0] a, logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_read(logic [4:0] a, output logic [31:0] d);
        reg_en = 1; reg_we = 0; reg_addr = a;
        @(negedge clk);
        reg_en = 0;
        d = reg_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic pulse_err();
        xfer_err = 1;
        @(negedge clk);
        xfer_err = 0;
    endtask

    // phase trial: limit L, acknowledge in cycle k after the start cycle
    task automatic phase_trial(int L, int k, bit dside);
        logic [31:0] v, e;
        reg_write(O_LIM, dside ? {L[15:0], 16'hFFFF} : {16'hFFFF, L[15:0]});
        if (dside) data_start = 1; else addr_start = 1;
        @(negedge clk);
        data_start = 0; addr_start = 0;
        for (int j = 1; j <= k; j++) begin
            if (j == k) begin
                if (dside) data_done = 1; else addr_done = 1;
            end
            @(negedge clk);
            data_done = 0; addr_done = 0;
        end
        repeat (L + 3) @(negedge clk);
        reg_read(O_ST, v);
        e = (k > L + 1) ? (dside ? 32'h2 : 32'h1) : 32'h0;
        chk(dside ? "R2 data timeout" : "R1 address timeout", v, e);
        reg_write(O_ST, 32'h7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        @(negedge clk);

        // R9 / R3 / R4 reset state
        reg_read(O_ST, v);  chk("R4 status after reset", v, 0);
        reg_read(O_RT, v);  chk("R9 route after reset", v, 0);
        reg_read(O_KD, v);  chk("R9 kind after reset", v, 0);
        reg_read(O_EN, v);  chk("R9 enable after reset", v, 0);
        reg_read(O_LIM, v); chk("R3 limits after reset", v, 32'hFFFFFFFF);
        chk("R9 outputs after reset", {29'd0, reset_req, irq, mcp}, 0);

        // R1, R2 sweeps
        for (int L = 0; L <= 4; L++)
            for (int k = 1; k <= 7; k++) begin
                phase_trial(L, k, 1'b0);
                phase_trial(L, k, 1'b1);
            end

        // latch all three events
        reg_write(O_LIM, 32'h0000_0000);
        addr_start = 1; data_start = 1; xfer_err = 1;
        @(negedge clk);
        addr_start = 0; data_start = 0; xfer_err = 0;
        repeat (3) @(negedge clk);
        reg_read(O_ST, v); chk("R4 all events latched", v, 32'h7);

        // R5 / R6 sweep over route, kind and enable for two status patterns
        for (int p = 0; p < 2; p++) begin
            logic [2:0] st;
            st = (p == 0) ? 3'b111 : 3'b101;
            if (p == 1) reg_write(O_ST, 32'h2);
            for (int r = 0; r < 8; r++)
                for (int kd = 0; kd < 8; kd++)
                    for (int e = 0; e < 8; e++) begin
                        logic [2:0] r3, k3, e3;
                        r3 = 3'(r); k3 = 3'(kd); e3 = 3'(e);
                        reg_write(O_RT, 32'(r));
                        reg_write(O_KD, 32'(kd));
                        reg_write(O_EN, 32'(e));
                        chk("R5 reset request", {31'd0, reset_req}, {31'd0, |(st & r3)});
                        chk("R6 interrupts", {30'd0, irq, mcp},
                            {30'd0, |(st & ~r3 & e3 & ~k3), |(st & ~r3 & e3 & k3)});
                    end
        end
        reg_write(O_RT, 0); reg_write(O_KD, 0); reg_write(O_EN, 0);

        // R7 first-event capture
        reg_write(O_ST, 32'h7);
        txn_addr = 32'hA1A1_0010; txn_attr = 8'h3C;
        pulse_err();
        txn_addr = 32'hB2B2_0020; txn_attr = 8'h5A;
        pulse_err();
        reg_write(O_LIM, 32'h0);
        txn_addr = 32'hC3C3_0030; txn_attr = 8'h77;
        addr_start = 1; @(negedge clk); addr_start = 0;
        repeat (3) @(negedge clk);
        reg_read(O_CA, v); chk("R7 first address kept", v, 32'hA1A1_0010);
        reg_read(O_CT, v); chk("R7 first attributes kept", v, 32'h3C);
        reg_write(O_ST, 32'h4);
        txn_addr = 32'hD4D4_0040;
        pulse_err();
        reg_read(O_CA, v); chk("R7 no re-arm while a bit is set", v, 32'hA1A1_0010);

        // R8 hard reset keeps the record
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
        reg_read(O_CA, v);  chk("R8 address survives hard reset", v, 32'hA1A1_0010);
        reg_read(O_CT, v);  chk("R8 attributes survive hard reset", v, 32'h3C);
        reg_read(O_ST, v);  chk("R4 status cleared by hard reset", v, 0);
        reg_read(O_LIM, v); chk("R3 limits restored by hard reset", v, 32'hFFFFFFFF);
        txn_addr = 32'hE5E5_0050; txn_attr = 8'h11;
        pulse_err();
        reg_read(O_CA, v); chk("R7 re-armed capture", v, 32'hE5E5_0050);
        reg_read(O_CT, v); chk("R7 re-armed attributes", v, 32'h11);

        // R4 set and clear in the same cycle; zero write; single clear
        reg_en = 1; reg_we = 1; reg_addr = O_ST; reg_wdata = 32'h4; xfer_err = 1;
        @(negedge clk);
        reg_en = 0; reg_we = 0; xfer_err = 0;
        reg_read(O_ST, v); chk("R4 set wins over clear", v, 32'h4);
        reg_write(O_ST, 32'h0);
        reg_read(O_ST, v); chk("R4 zero write no effect", v, 32'h4);
        reg_write(O_ST, 32'h4);
        reg_read(O_ST, v); chk("R4 write one clears", v, 32'h0);

        summary();
    end
endmodule